// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block turns a byte-wide command stream from a host link into accesses on a small register file. Each command byte carries an operation code and a four-bit payload, so a full address or data byte always costs two command bytes. Reads return one whole byte on a separate response port, which holds a single pending byte. The command port stalls while that byte has not been taken.

The register file holds a fixed identification byte, a scratch byte for link testing, and a mode byte that drives an output. It also holds six read-only bytes that expose two externally supplied 24-bit capture positions. A read variant steps the address forward after each byte, so the host can walk the position bytes with a run of identical commands.

Top module: `nibreg_decoder`

## Requirements
- R1: A command byte is taken on a rising edge when `cmd_valid` and `cmd_ready` are both high. Bits [7:4] hold the operation and bits [3:0] the payload. The operation codes are: 0x1 load address low nibble, 0x2 load address high nibble, 0x3 stage data low nibble, 0x4 complete data byte and write, 0x5 read, 0x6 read then advance.
- R2: The 8-bit address is built from a low-nibble command and a high-nibble command, and each command replaces only its own nibble. The address resets to 0x00.
- R3: A write command (0x4) writes the byte {payload, staged low nibble} to the current address. The result is visible in the cycle after the command is taken.
- R4: Any number of write commands may follow one address load, and each one writes the same address without a reload. The staged low nibble is kept across writes until a new 0x3 command replaces it.
- R5: A read command (0x5 or 0x6) raises `rsp_valid` in the cycle after it is taken. `rsp_byte` then carries the register at the address the read was issued to. Code 0x5 leaves the address unchanged.
- R6: Code 0x6 adds one to the address after the read, and the address wraps from 0xFF to 0x00.
- R7: Address 0x00 reads 0xA6, and writes to it have no effect. Addresses that are not mapped read 0x00 and ignore writes.
- R8: Address 0x01 is a scratch byte that reads back the last byte written to it, for every byte value.
- R9: Addresses 0x08 to 0x0D read the trigger position bytes and then the stop position bytes, each least significant byte first. These addresses ignore writes.
- R10: A write to address 0x02 sets `mode_out`. Reading 0x02 returns `mode_out`, except that bit 5 shows `trig_fired`.
- R11: `cmd_ready` is low while `rsp_valid` is high. An untaken response keeps `rsp_byte` unchanged until a cycle with `rsp_ready` high clears it. Commands offered during the stall have no effect.
- R12: Operation codes 0x0 and 0x7 to 0xF are ignored, and the address and the staged nibble stay unchanged.
- R13: After reset `rsp_valid` is low, `cmd_ready` is high and `mode_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_byte | input | 8 | Operation [7:4], payload [3:0] |
| cmd_ready | output | 1 | Command byte can be taken |
| rsp_valid | output | 1 | Response byte pending |
| rsp_byte | output | 8 | Response data |
| rsp_ready | input | 1 | Host takes the response byte |
| trig_pos | input | 24 | Trigger position, read-only |
| stop_pos | input | 24 | Stop position, read-only |
| trig_fired | input | 1 | Trigger-fired status, shown in mode readback |
| mode_out | output | 8 | Mode register value |

## Verification
The read-then-advance command captures the response byte and steps the address on the same edge, so the captured byte must come from the address before the step. The bench checks this by walking all 256 addresses from 0x00 with back-to-back advancing reads and comparing each byte with a model indexed by the pre-step address. After the wrap, plain reads confirm the address is back at 0x00. The second same-cycle case is a command offered while the response is still pending. The bench offers address-loading commands during a held response, then releases it and reads again to show that the address did not move.

// File: rtl/nibreg_pkg.sv
// Shared constants for the nibble-command register decoder.
// Assumes 8-bit addresses and bytes, each loaded as two nibbles.
package nibreg_pkg;
    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OP_ADDR_LO  = 4'h1,
        OP_ADDR_HI  = 4'h2,
        OP_DATA_LO  = 4'h3,
        OP_DATA_WR  = 4'h4,
        OP_READ     = 4'h5,
        OP_READ_INC = 4'h6
    } nib_op_e;

    localparam logic [ADDR_W-1:0] A_IDENT   = 8'h00;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 8'h01;
    localparam logic [ADDR_W-1:0] A_MODE    = 8'h02;
    localparam logic [ADDR_W-1:0] A_POSBASE = 8'h08;
    localparam int               FIRED_BIT = 5;
endpackage

// File: rtl/nibreg_cmd_decode.sv
// Command decoder: holds the current address and the staged data nibble,
// and turns each taken command byte into write and read strobes.
// Assumes cmd_fire is already qualified by the stall from the response side.
module nibreg_cmd_decode
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  logic [7:0]        cmd_byte,
    output logic [ADDR_W-1:0] addr_q,
    output logic [3:0]        stage_q,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en
);
    logic [3:0] op;
    logic [3:0] pl;

    assign op = cmd_byte[7:4];
    assign pl = cmd_byte[3:0];

    // Update the address nibbles, the staged nibble and the post-read step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            stage_q <= '0;
        end else if (cmd_fire) begin
            case (op)
                OP_ADDR_LO:  addr_q[3:0] <= pl;
                OP_ADDR_HI:  addr_q[7:4] <= pl;
                OP_DATA_LO:  stage_q     <= pl;
                OP_READ_INC: addr_q      <= addr_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Strobes for the register file and the response buffer.
    always_comb begin
        wr_en   = cmd_fire && (op == OP_DATA_WR);
        rd_en   = cmd_fire && ((op == OP_READ) || (op == OP_READ_INC));
        wr_data = {pl, stage_q};
    end
endmodule

// File: rtl/nibreg_regfile.sv
// Register file: fixed identification byte, scratch byte, mode byte and
// read-only position bytes taken from inputs. Reads are combinational.
// Assumes POS_W is a multiple of 8.
module nibreg_regfile
    import nibreg_pkg::*;
#(
    parameter int               POS_W    = 24,
    parameter logic [BYTE_W-1:0] ID_VALUE = 8'hA6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [POS_W-1:0]  trig_pos,
    input  logic [POS_W-1:0]  stop_pos,
    input  logic              trig_fired,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int POS_BYTES = POS_W / 8;
    localparam int POS_SLOTS = 2 * POS_BYTES;

    logic [BYTE_W-1:0] scratch_q;
    logic [BYTE_W-1:0] pos_bytes [POS_SLOTS];

    // Lay out trigger bytes then stop bytes, least significant first.
    for (genvar g = 0; g < POS_BYTES; g++) begin : g_pos
        assign pos_bytes[g]             = trig_pos[g*8 +: 8];
        assign pos_bytes[POS_BYTES + g] = stop_pos[g*8 +: 8];
    end

    // Writable registers: scratch and mode only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            mode_q    <= '0;
        end else if (wr_en) begin
            if (addr == A_SCRATCH) scratch_q <= wr_data;
            if (addr == A_MODE)    mode_q    <= wr_data;
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (addr == A_IDENT) begin
            rd_data = ID_VALUE;
        end else if (addr == A_SCRATCH) begin
            rd_data = scratch_q;
        end else if (addr == A_MODE) begin
            rd_data            = mode_q;
            rd_data[FIRED_BIT] = trig_fired;
        end
        for (int i = 0; i < POS_SLOTS; i++) begin
            if (addr == A_POSBASE + ADDR_W'(i)) rd_data = pos_bytes[i];
        end
    end
endmodule

// File: rtl/nibreg_rsp_buf.sv
// Single-entry response buffer with a valid flag.
// Assumes load never arrives while an entry is held (the command side stalls).
module nibreg_rsp_buf
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte
);
    // Capture a read byte, hold it until the host takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_byte  <= load_data;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nibreg_decoder.sv
// Top: nibble-command register access decoder. Connects the command
// decoder, register file and response buffer; stalls commands while a
// response byte is pending.
module nibreg_decoder
    import nibreg_pkg::*;
#(
    parameter int               POS_W    = 24,
    parameter logic [BYTE_W-1:0] ID_VALUE = 8'hA6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [7:0]        rsp_byte,
    input  logic              rsp_ready,
    input  logic [POS_W-1:0]  trig_pos,
    input  logic [POS_W-1:0]  stop_pos,
    input  logic              trig_fired,
    output logic [7:0]        mode_out
);
    logic              cmd_fire;
    logic [ADDR_W-1:0] dec_addr;
    logic [3:0]        dec_stage;
    logic              wr_en;
    logic              rd_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    assign cmd_ready = !rsp_valid;
    assign cmd_fire  = cmd_valid && cmd_ready;

    nibreg_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_fire (cmd_fire),
        .cmd_byte (cmd_byte),
        .addr_q   (dec_addr),
        .stage_q  (dec_stage),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en)
    );

    nibreg_regfile #(.POS_W(POS_W), .ID_VALUE(ID_VALUE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (dec_addr),
        .wr_data    (wr_data),
        .trig_pos   (trig_pos),
        .stop_pos   (stop_pos),
        .trig_fired (trig_fired),
        .mode_q     (mode_out),
        .rd_data    (rd_data)
    );

    nibreg_rsp_buf u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_en),
        .load_data (rd_data),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte)
    );
endmodule

// File: rtl/nibreg_checker.sv
// Protocol and state checks for nibreg_decoder, attached with bind.
// Observes ports plus the decoder's address and staged nibble.
module nibreg_checker
    import nibreg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_byte,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [7:0] rsp_byte,
    input logic [7:0] mode_out,
    input logic [7:0] cur_addr,
    input logic [3:0] stage
);
    logic       fire;
    logic [3:0] op;
    logic       is_known;
    assign fire     = cmd_valid && cmd_ready;
    assign op       = cmd_byte[7:4];
    assign is_known = (op >= 4'h1) && (op <= 4'h6);

    p_reset_r13: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && mode_out == 8'h00);

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_byte));

    p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (op == OP_READ || op == OP_READ_INC) |=> rsp_valid);

    p_no_rsp_without_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid && !(fire && (op == OP_READ || op == OP_READ_INC)) |=> !rsp_valid);

    p_read_keeps_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_READ |=> $stable(cur_addr));

    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_READ_INC |=> cur_addr == $past(cur_addr) + 8'd1);

    p_mode_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_DATA_WR && cur_addr == A_MODE
        |=> mode_out == $past({cmd_byte[3:0], stage}));

    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && op == OP_DATA_WR && cur_addr == A_MODE) |=> $stable(mode_out));

    p_unknown_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !is_known |=> $stable(cur_addr) && $stable(stage));

    p_stall_noeffect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> $stable(cur_addr) && $stable(stage));
endmodule

bind nibreg_decoder nibreg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_byte  (cmd_byte),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_byte  (rsp_byte),
    .mode_out  (mode_out),
    .cur_addr  (dec_addr),
    .stage     (dec_stage)
);

// File: tb/sim_nibreg_decoder.sv
module sim_nibreg_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cmd_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_byte;
    logic        rsp_ready = 1'b0;
    logic [23:0] trig_pos = 24'h0;
    logic [23:0] stop_pos = 24'h0;
    logic        trig_fired = 1'b0;
    logic [7:0]  mode_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] scr_m = 8'h00;
    logic [7:0] mode_m = 8'h00;

    always #2 clk = ~clk;

    nibreg_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .rsp_ready(rsp_ready), .trig_pos(trig_pos), .stop_pos(stop_pos),
        .trig_fired(trig_fired), .mode_out(mode_out)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected below 150000", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] a);
        case (a)
            8'h00: return 8'hA6;
            8'h01: return scr_m;
            8'h02: return {mode_m[7:6], trig_fired, mode_m[4:0]};
            8'h08: return trig_pos[7:0];
            8'h09: return trig_pos[15:8];
            8'h0A: return trig_pos[23:16];
            8'h0B: return stop_pos[7:0];
            8'h0C: return stop_pos[15:8];
            8'h0D: return stop_pos[23:16];
            default: return 8'h00;
        endcase
    endfunction

    // Offer one command at a negedge; return at the negedge after it is taken.
    task automatic send(input logic [3:0] op, input logic [3:0] pl);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = {op, pl};
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] a);
        send(4'h1, a[3:0]);
        send(4'h2, a[7:4]);
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        set_addr(a);
        send(4'h3, d[3:0]);
        send(4'h4, d[7:4]);
    endtask

    // Issue a read, check the response one cycle later, then pop it.
    task automatic rd_check(input logic [3:0] op, input logic [7:0] exp, input string req);
        send(op, 4'h0);
        check(rsp_valid === 1'b1, {req, " rsp_valid"}, {7'd0, rsp_valid}, 8'h01);
        check(rsp_byte === exp, req, rsp_byte, exp);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        check(rsp_valid === 1'b0, "R13 rsp_valid", {7'd0, rsp_valid}, 8'h00);
        check(cmd_ready === 1'b1, "R13 cmd_ready", {7'd0, cmd_ready}, 8'h01);
        check(mode_out === 8'h00, "R13 mode_out", mode_out, 8'h00);

        // R7 identification, write ignored; R2 address starts at 0
        rd_check(4'h5, 8'hA6, "R7 ident at reset address R2");
        wr_byte(8'h00, 8'h5A);
        rd_check(4'h5, 8'hA6, "R7 ident after write");
        wr_byte(8'h40, 8'h77);
        rd_check(4'h5, 8'h00, "R7 unmapped reads zero");

        // R8 scratch sequence and full sweep; R3 write on high nibble
        wr_byte(8'h01, 8'h55); scr_m = 8'h55;
        rd_check(4'h5, 8'h55, "R8 scratch 55");
        wr_byte(8'h01, 8'hAA); scr_m = 8'hAA;
        rd_check(4'h5, 8'hAA, "R8 scratch AA");
        for (int v = 0; v < 256; v++) begin
            wr_byte(8'h01, 8'(v)); scr_m = 8'(v);
            rd_check(4'h5, 8'(v), "R8 R3 scratch sweep");
        end

        // R4 several writes after one address load; staged nibble kept
        set_addr(8'h01);
        send(4'h3, 4'h3); send(4'h4, 4'h1);
        send(4'h4, 4'h2); scr_m = 8'h23;
        rd_check(4'h5, 8'h23, "R4 staged nibble reused");
        send(4'h3, 4'h9); send(4'h4, 4'hE); scr_m = 8'hE9;
        rd_check(4'h5, 8'hE9, "R4 second byte same address");

        // R10 mode register with both fired states
        for (int v = 0; v < 256; v++) begin
            trig_fired = v[0] ^ v[5];
            wr_byte(8'h02, 8'(v)); mode_m = 8'(v);
            check(mode_out === 8'(v), "R10 mode_out", mode_out, 8'(v));
            rd_check(4'h5, model(8'h02), "R10 mode readback fired bit");
        end

        // R9 positions via advancing reads; R6
        trig_pos = 24'h3C2B1A;
        stop_pos = 24'hF0E1D2;
        set_addr(8'h08);
        for (int i = 0; i < 6; i++) rd_check(4'h6, model(8'(8 + i)), "R9 R6 position bytes");
        wr_byte(8'h08, 8'h99);
        rd_check(4'h5, 8'h1A, "R9 position ignores write");

        // R6 R5 walk all 256 addresses; byte from pre-step address, wrap
        set_addr(8'h00);
        for (int a = 0; a < 256; a++) rd_check(4'h6, model(8'(a)), "R6 advancing sweep");
        rd_check(4'h5, 8'hA6, "R6 wrap to zero");
        rd_check(4'h5, 8'hA6, "R5 plain read keeps address");

        // R11 stall: held response, offered commands ignored
        set_addr(8'h01);
        send(4'h5, 4'h0);
        check(cmd_ready === 1'b0, "R11 cmd_ready low", {7'd0, cmd_ready}, 8'h00);
        cmd_valid = 1'b1; cmd_byte = 8'h1F;
        @(negedge clk);
        cmd_byte = 8'h2F;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(rsp_valid === 1'b1, "R11 rsp held", {7'd0, rsp_valid}, 8'h01);
        check(rsp_byte === scr_m, "R11 rsp stable", rsp_byte, scr_m);
        rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
        check(cmd_ready === 1'b1, "R11 ready after pop", {7'd0, cmd_ready}, 8'h01);
        rd_check(4'h5, scr_m, "R11 address unchanged by stalled commands");

        // R12 unknown codes leave address and staged nibble
        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 6) continue;
            set_addr(8'h01);
            send(4'h3, 4'h5);
            send(4'(op), 4'hA);
            send(4'h4, 4'hC); scr_m = 8'hC5;
            rd_check(4'h5, 8'hC5, "R12 unknown opcode ignored");
        end

        // R1 field positions: payload nibble in [3:0] selects address 0x0D
        set_addr(8'h0D);
        rd_check(4'h5, stop_pos[23:16], "R1 R2 nibble fields");

        summary();
    end
endmodule